// File: doc/BRIEF.md
# Initialization Block Fetch Sequencer

This block loads a controller's configuration from a parameter block in system memory. A host sets a start command. The sequencer then forms a word-aligned start address from two 16-bit host address registers and walks the block with 32-bit reads through a simple request/acknowledge read master. It splits each returned word into logical entries and presents every entry, with its index, on a one-cycle load strobe for the configuration registers that sit outside this block.

A size select bit picks the layout. With the bit at 0 (the default), entries are 16 bits wide, and each 32-bit read yields two of them. With the bit at 1, entries are 32 bits wide, and each read yields one. The sequencer advances once every two input clocks. After the last entry has been loaded, it sets a sticky completion flag, which the host clears with a write-one pulse. An interrupt output follows that flag only while the host's interrupt enable is high.

Top module: `ifetch_seq`

## Requirements
- R1: The first read address is `{base_hi, base_lo}` with bits 1:0 forced to 0, sampled when the fetch starts. Each later read is 4 bytes above the one before it.
- R2: With `wide_mode`=0 at start, exactly N_ENTRIES/2 reads are issued. Read k loads entry 2k from bits 15:0 and entry 2k+1 from bits 31:16, each zero-extended to 32 bits.
- R3: With `wide_mode`=1 at start, exactly N_ENTRIES reads are issued. Read k loads entry k as the full 32-bit word.
- R4: Every read is a 32-bit, word-aligned access (`rd_addr[1:0]`=0). `rd_req` stays high with a stable `rd_addr` until the cycle in which `rd_ack` is sampled high.
- R5: `cfg_we` is high for one clock per entry. Entry indices run in ascending order from 0 to N_ENTRIES-1. Two strobes are never on consecutive clocks, because the sequencer advances every second clock.
- R6: `done` rises on the clock after the last entry's strobe, and `busy` is low from that clock.
- R7: `done` stays high until a `done_clr` pulse clears it.
- R8: `irq` is high exactly when `done` is high and `irq_en` is high.
- R9: An `init_cmd` pulse while `busy` is high is ignored. No further fetch follows the current one.
- R10: After reset, `rd_req`, `cfg_we`, `busy`, `done` and `irq` are all low.
- R11: Changes to `wide_mode`, `base_lo` or `base_hi` during a fetch do not affect that fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| base_lo | input | 16 | Low half of the parameter block address |
| base_hi | input | 16 | High half of the parameter block address |
| wide_mode | input | 1 | Entry size select: 0 for 16-bit entries, 1 for 32-bit entries |
| irq_en | input | 1 | Interrupt enable |
| init_cmd | input | 1 | Start pulse |
| done_clr | input | 1 | Write-one pulse that clears the completion flag |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | 32 | Read byte address, word aligned |
| rd_ack | input | 1 | Read acknowledge, valid together with rd_data |
| rd_data | input | 32 | Read return data |
| cfg_we | output | 1 | Configuration entry load strobe |
| cfg_idx | output | 3 | Index of the entry being loaded |
| cfg_data | output | 32 | Value of the entry being loaded |
| busy | output | 1 | Fetch pending or in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |

## Verification
The main function is exercised in four ways:
- A 16-bit-entry fetch with zero read latency tests whether the halfword order inside each word is correct and whether the number of reads is halved.
- A 32-bit-entry fetch with a three-cycle latency tests whether full words pass through unsplit and whether the request is held while the read stalls.
- An unaligned base value tests that the low address bits are forced to zero.
- A fetch disturbed halfway through, with a second start pulse and a changed size bit and base, tests that the sampled configuration is kept and that the start pulse issued while busy is dropped.

Memory data is a function of the address whose two halves always differ, so a swapped halfword or a repeated entry shows up as a mismatch.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_UNPK  = 2'd2
  } seq_state_t;

endpackage

// File: rtl/ifetch_step_gen.sv
module ifetch_step_gen (
  input  logic clk,
  input  logic rst_n,
  output logic step
);

  logic ph_q;
  logic ph_d;

  always_comb begin
    ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign step = ph_q;

  // R5: the step enable never lasts two clocks
  a_r5_step_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);

endmodule

// File: rtl/ifetch_reader.sv
module ifetch_reader #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              have,
  output logic [DATA_W-1:0] word
);

  logic              req_q, req_d;
  logic              have_q, have_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] word_q, word_d;

  always_comb begin
    req_d  = req_q;
    have_d = have_q;
    addr_d = addr_q;
    word_d = word_q;
    if (start) begin
      req_d  = 1'b1;
      have_d = 1'b0;
      addr_d = addr_in;
    end else if (req_q && rd_ack) begin
      req_d  = 1'b0;
      have_d = 1'b1;
      word_d = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      have_q <= 1'b0;
      addr_q <= '0;
      word_q <= '0;
    end else begin
      req_q  <= req_d;
      have_q <= have_d;
      addr_q <= addr_d;
      word_q <= word_d;
    end
  end

  assign rd_req  = req_q;
  assign rd_addr = addr_q;
  assign have    = have_q;
  assign word    = word_q;

  // R4: an unanswered request keeps its address
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R4: only word-aligned addresses go out
  a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[1:0] == 2'b00));

endmodule

// File: rtl/ifetch_unpack.sv
module ifetch_unpack #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word,
  input  logic              wide,
  input  logic              upper,
  output logic [DATA_W-1:0] entry
);

  localparam int HALF = DATA_W / 2;

  always_comb begin
    if (wide) begin
      entry = word;
    end else if (upper) begin
      entry = {{HALF{1'b0}}, word[DATA_W-1:HALF]};
    end else begin
      entry = {{HALF{1'b0}}, word[HALF-1:0]};
    end
  end

endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
  import ifetch_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int HALF_W    = 16,
  parameter int DATA_W    = 32,
  localparam int ADDR_W   = 2 * HALF_W,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] base_lo,
  input  logic [HALF_W-1:0] base_hi,
  input  logic              wide_mode,
  input  logic              irq_en,
  input  logic              init_cmd,
  input  logic              done_clr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              cfg_we,
  output logic [IDX_W-1:0]  cfg_idx,
  output logic [DATA_W-1:0] cfg_data,
  output logic              busy,
  output logic              done,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK   = ~ADDR_W'(3);
  localparam logic [IDX_W-1:0]  LAST_WIDE    = IDX_W'(N_ENTRIES - 1);
  localparam logic [IDX_W-1:0]  LAST_NARROW  = IDX_W'(N_ENTRIES / 2 - 1);
  localparam int                PAD_W        = ADDR_W - IDX_W - 2;

  seq_state_t        state_q, state_d;
  logic [IDX_W-1:0]  wcnt_q, wcnt_d;
  logic              half_q, half_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              wide_q, wide_d;
  logic              pend_q, pend_d;
  logic              done_q, done_d;

  logic              step;
  logic              start_fetch;
  logic [ADDR_W-1:0] fetch_addr;
  logic [ADDR_W-1:0] new_base;
  logic [IDX_W-1:0]  wcnt_inc;
  logic              have;
  logic [DATA_W-1:0] word;
  logic              last_word;
  logic              word_end;

  ifetch_step_gen u_step (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step)
  );

  ifetch_reader #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_fetch),
    .addr_in (fetch_addr),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_ack  (rd_ack),
    .rd_data (rd_data),
    .have    (have),
    .word    (word)
  );

  ifetch_unpack #(
    .DATA_W (DATA_W)
  ) u_unp (
    .word  (word),
    .wide  (wide_q),
    .upper (half_q),
    .entry (cfg_data)
  );

  always_comb begin
    new_base   = {base_hi, base_lo} & ALIGN_MASK;
    wcnt_inc   = wcnt_q + 1'b1;
    last_word  = wide_q ? (wcnt_q == LAST_WIDE) : (wcnt_q == LAST_NARROW);
    word_end   = wide_q || half_q;
    fetch_addr = (state_q == ST_IDLE) ? new_base
               : base_q + {{PAD_W{1'b0}}, wcnt_inc, 2'b00};
  end

  // next-state process
  always_comb begin
    state_d     = state_q;
    wcnt_d      = wcnt_q;
    half_d      = half_q;
    base_d      = base_q;
    wide_d      = wide_q;
    pend_d      = pend_q;
    done_d      = done_q;
    start_fetch = 1'b0;
    cfg_we      = 1'b0;

    if (init_cmd && (state_q == ST_IDLE) && !pend_q) begin
      pend_d = 1'b1;
    end
    if (done_clr) begin
      done_d = 1'b0;
    end

    if (step) begin
      unique case (state_q)
        ST_IDLE: begin
          if (pend_q) begin
            pend_d      = 1'b0;
            base_d      = new_base;
            wide_d      = wide_mode;
            wcnt_d      = '0;
            half_d      = 1'b0;
            start_fetch = 1'b1;
            state_d     = ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (have) begin
            half_d  = 1'b0;
            state_d = ST_UNPK;
          end
        end
        ST_UNPK: begin
          cfg_we = 1'b1;
          if (word_end) begin
            if (last_word) begin
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              wcnt_d      = wcnt_inc;
              start_fetch = 1'b1;
              state_d     = ST_FETCH;
            end
          end else begin
            half_d = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      half_q  <= 1'b0;
      base_q  <= '0;
      wide_q  <= 1'b0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      half_q  <= half_d;
      base_q  <= base_d;
      wide_q  <= wide_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
    end
  end

  assign cfg_idx = wide_q ? wcnt_q : {wcnt_q[IDX_W-2:0], half_q};
  assign busy    = pend_q || (state_q != ST_IDLE);
  assign done    = done_q;
  assign irq     = done_q && irq_en;

  // R5: load strobes are spaced by the half-rate step
  a_r5_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !cfg_we);

  // R6: completion only follows an entry load
  a_r6_done_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cfg_we));

  // R7: completion flag persists without a clear
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> done);

  // R8: interrupt gated by enable
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  // R9: no read request while idle with nothing pending
  a_r9_no_stray_read: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);

endmodule

// File: tb/sim_ifetch_seq.sv
module sim_ifetch_seq;

  localparam int N     = 8;
  localparam int IDX_W = 3;

  logic        clk;
  logic        rst_n;
  logic [15:0] base_lo, base_hi;
  logic        wide_mode, irq_en, init_cmd, done_clr;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack;
  logic [31:0] rd_data;
  logic        cfg_we;
  logic [IDX_W-1:0] cfg_idx;
  logic [31:0] cfg_data;
  logic        busy, done, irq;

  int checks = 0;
  int errors = 0;
  int lat    = 0;
  int reads  = 0;
  bit ended  = 0;

  logic [39:0] exp_q[$];
  logic [31:0] addr_q[$];

  ifetch_seq u0 (
    .clk(clk), .rst_n(rst_n), .base_lo(base_lo), .base_hi(base_hi),
    .wide_mode(wide_mode), .irq_en(irq_en), .init_cmd(init_cmd),
    .done_clr(done_clr), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .busy(busy), .done(done),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {~a[15:0], a[15:0] ^ 16'h3C5A};
  endfunction

  task automatic check(input bit ok, input string req, input logic [39:0] act,
                       input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // memory responder, also checks the address sequence (R1, R4)
  initial begin
    rd_ack  = 1'b0;
    rd_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n && rd_req && !rd_ack) begin
        reads++;
        if (addr_q.size() == 0) begin
          check(1'b0, "R9 unexpected read", {8'h0, rd_addr}, 40'h0);
        end else begin
          logic [31:0] ea;
          ea = addr_q.pop_front();
          check(rd_addr == ea, "R1 read address", {8'h0, rd_addr}, {8'h0, ea});
        end
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          check(rd_req, "R4 request held", {39'h0, rd_req}, 40'h1);
        end
        rd_ack  = 1'b1;
        rd_data = mem_word(rd_addr);
        @(negedge clk);
        rd_ack  = 1'b0;
      end
    end
  end

  // monitor: scoreboard compare of load strobes (R2, R3, R5, R6)
  initial begin
    int  gap = 10;
    bit  chk_done = 0;
    forever begin
      @(negedge clk);
      if (chk_done) begin
        chk_done = 0;
        check(done && !busy, "R6 done after last load",
              {38'h0, done, busy}, 40'h2);
      end
      gap++;
      if (cfg_we) begin
        check(gap >= 2, "R5 strobe spacing", 40'(gap), 40'd2);
        gap = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected load", {5'h0, cfg_idx, cfg_data}, 40'h0);
        end else begin
          logic [39:0] e;
          e = exp_q.pop_front();
          check({5'h0, cfg_idx, cfg_data} == e, "R2/R3 entry load",
                {5'h0, cfg_idx, cfg_data}, e);
          if (exp_q.size() == 0) chk_done = 1;
        end
      end
    end
  end

  task automatic pulse_init();
    init_cmd = 1'b1;
    @(negedge clk);
    init_cmd = 1'b0;
  endtask

  // driver: pushes expected reads and entries, then starts a fetch
  task automatic start_fetch(input logic [15:0] lo, input logic [15:0] hi,
                             input bit wide);
    logic [31:0] b;
    b = {hi, lo} & 32'hFFFF_FFFC;
    base_lo   = lo;
    base_hi   = hi;
    wide_mode = wide;
    if (wide) begin
      for (int k = 0; k < N; k++) begin
        addr_q.push_back(b + 32'(4 * k));
        exp_q.push_back({5'h0, 3'(k), mem_word(b + 32'(4 * k))});
      end
    end else begin
      for (int k = 0; k < N / 2; k++) begin
        logic [31:0] w;
        w = mem_word(b + 32'(4 * k));
        addr_q.push_back(b + 32'(4 * k));
        exp_q.push_back({5'h0, 3'(2 * k),     16'h0, w[15:0]});
        exp_q.push_back({5'h0, 3'(2 * k + 1), 16'h0, w[31:16]});
      end
    end
    reads = 0;
    pulse_init();
  endtask

  task automatic wait_done(input string req, input int nreads);
    int n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, req, {39'h0, done}, 40'h1);
    @(negedge clk);
    check(exp_q.size() == 0 && addr_q.size() == 0, req,
          40'(exp_q.size()), 40'h0);
    check(reads == nreads, req, 40'(reads), 40'(nreads));
  endtask

  task automatic clear_done();
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    check(done == 1'b0, "R7 clear", {39'h0, done}, 40'h0);
  endtask

  initial begin
    #(4 * 200000);
    check(1'b0, "watchdog", 40'h0, 40'h1);
    finish_sim();
  end

  initial begin
    rst_n = 1'b0; base_lo = '0; base_hi = '0; wide_mode = 1'b0;
    irq_en = 1'b0; init_cmd = 1'b0; done_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check({rd_req, cfg_we, busy, done, irq} == 5'b0, "R10 reset state",
          {35'h0, rd_req, cfg_we, busy, done, irq}, 40'h0);

    // R2, R8: narrow layout, no latency, interrupt enabled
    irq_en = 1'b1; lat = 0;
    start_fetch(16'h2000, 16'h0001, 1'b0);
    wait_done("R2 narrow fetch", N / 2);
    check(irq == 1'b1, "R8 irq with enable", {39'h0, irq}, 40'h1);

    // R7: flag stays set, then clears
    repeat (10) @(negedge clk);
    check(done == 1'b1, "R7 sticky", {39'h0, done}, 40'h1);
    clear_done();
    check(irq == 1'b0, "R8 irq follows done", {39'h0, irq}, 40'h0);

    // R3, R4, R8: wide layout, slow memory, interrupt disabled
    irq_en = 1'b0; lat = 3;
    start_fetch(16'h4440, 16'h00A0, 1'b1);
    wait_done("R3 wide fetch", N);
    check(irq == 1'b0, "R8 irq masked", {39'h0, irq}, 40'h0);
    irq_en = 1'b1;
    #1;
    check(irq == 1'b1, "R8 irq enabled late", {39'h0, irq}, 40'h1);
    @(negedge clk);
    clear_done();

    // R1: unaligned base is word aligned
    lat = 1;
    start_fetch(16'h1236, 16'h7FFF, 1'b0);
    wait_done("R1 aligned base", N / 2);
    clear_done();

    // R9, R11: disturbance during a fetch
    lat = 2;
    start_fetch(16'h0100, 16'h0002, 1'b0);
    repeat (6) @(negedge clk);
    check(busy == 1'b1, "R9 busy mid fetch", {39'h0, busy}, 40'h1);
    wide_mode = 1'b1;
    base_lo   = 16'hBEE0;
    base_hi   = 16'h0F0F;
    pulse_init();
    wait_done("R11 fetch unaffected", N / 2);
    repeat (40) @(negedge clk);
    check(reads == N / 2 && !busy, "R9 second start ignored",
          {7'h0, busy, 32'(reads)}, 40'(N / 2));
    clear_done();

    finish_sim();
  end

endmodule